// File: doc/BRIEF.md
# Memory-Map Chip-Select Decoder with Wait States

This block sits between a processor with a 20-bit address bus and two banks of memory devices. It turns the address, the memory/IO qualifier and the read and write strobes into active-low chip selects and enables. The slow ROM bank lives at the top of the address space and the fast SRAM bank at the bottom. The region between them, and every IO cycle, leaves all selects idle.

The ROM bank is eight 4 KB devices covering F8000h to FFFFFh. This range contains the address the processor fetches from first after reset. The SRAM bank is sixteen 32 KB devices covering 00000h to 7FFFFh. Each region takes its device index from a different address slice.

Decoded ROM accesses are slower than the bus allows, so the block raises a wait request at the start of every strobed ROM access. It holds the request for a parameterised number of clocks (default one) and then releases it.

Top module: `memmap_cs_dec`

## Requirements
- R1: When io_m is 0 and addr[19:15] is all ones, rom_cs_n bit addr[14:12] is 0 and every other bit of rom_cs_n and ram_cs_n is 1.
- R2: When io_m is 0 and addr[19] is 0, ram_cs_n bit addr[18:15] is 0 and every other bit of ram_cs_n and rom_cs_n is 1.
- R3: When io_m is 1 (IO cycle), every chip select and enable output is 1 and wait_req is 0, whatever the address and strobes.
- R4: A memory address from 80000h to F7FFFh drives every chip select and enable output to 1.
- R5: Address FFFF0h in a memory cycle selects ROM device 7 (rom_cs_n = 8'h7F).
- R6: When a ROM device is selected and rd_n or wr_n is 0, wait_req is 1 from the first cycle of that access for WAIT_STATES rising clock edges. It is then 0 until both strobes return to 1. A new strobed ROM access starts the count again.
- R7: wait_req is never 1 while an SRAM device is selected.
- R8: rom_oe_n equals rd_n while a ROM device is selected, and is 1 otherwise.
- R9: ram_oe_n equals rd_n and ram_we_n equals wr_n while an SRAM device is selected; both are 1 otherwise.
- R10: At most one bit across rom_cs_n and ram_cs_n is 0 at any time.
- R11: After reset, with idle strobes and an unmapped address, all outputs are 1 except wait_req, which is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the wait-state counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Processor address |
| io_m | input | 1 | 1 for an IO cycle, 0 for a memory cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| rom_cs_n | output | 8 | Active-low ROM device selects |
| ram_cs_n | output | 16 | Active-low SRAM device selects |
| rom_oe_n | output | 1 | Active-low ROM output enable |
| ram_oe_n | output | 1 | Active-low SRAM output enable |
| ram_we_n | output | 1 | Active-low SRAM write enable |
| wait_req | output | 1 | Active-high wait request to the processor |

## Verification
The only state is the wait counter. If it holds a wrong value, wait_req is wrong in the very cycle a ROM strobe goes low, or one clock later when the release is due. A counter that fails to clear shows up on the next ROM access, which then gets no wait or a short one. The selects are purely combinational, so a decode error appears at the ports as soon as the address settles. The bench therefore sweeps every device index in both regions, the unmapped gap and IO cycles, and samples each output before the next edge.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  localparam int ADDR_W   = 20;
  // slow bank: top 32 KB, device index from a 3-bit slice
  localparam int ROM_N    = 8;
  localparam int ROM_IDX  = 12;
  localparam int ROM_TAGL = 15;
  localparam int ROM_TAGW = ADDR_W - ROM_TAGL;
  localparam int ROM_TAGV = (1 << ROM_TAGW) - 1;
  // fast bank: bottom 512 KB, device index from a 4-bit slice
  localparam int RAM_N    = 16;
  localparam int RAM_IDX  = 15;
  localparam int RAM_TAGL = ADDR_W - 1;
  localparam int RAM_TAGW = 1;
  localparam int RAM_TAGV = 0;
endpackage

// File: rtl/region_dec.sv
module region_dec #(
  parameter int ADDR_W = 20,
  parameter int DEV_N  = 8,
  parameter int IDX_LO = 12,
  parameter int TAG_LO = 15,
  parameter int TAG_W  = 5,
  parameter int TAG_V  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_cyc,
  output logic              hit,
  output logic [DEV_N-1:0]  sel_n
);
  localparam int IDX_W = $clog2(DEV_N);

  logic [IDX_W-1:0] idx;

  always_comb begin
    hit = mem_cyc && (addr[TAG_LO +: TAG_W] == TAG_W'(TAG_V));
    idx = addr[IDX_LO +: IDX_W];
  end

  for (genvar d = 0; d < DEV_N; d++) begin : g_dev
    always_comb sel_n[d] = !(hit && (idx == IDX_W'(d)));
  end

  // R1/R2: a region never drives two of its own selects at once
  assert_region_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n));
  assert_region_hit_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($countones(~sel_n) == 1));
endmodule

// File: rtl/wait_gen.sv
module wait_gen #(
  parameter int WAIT_STATES = 1
) (
  input  logic clk,
  input  logic rst_q_n,
  input  logic slow_acc,
  output logic wait_req
);
  localparam int CW = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);

  if (WAIT_STATES == 0) begin : g_none
    always_comb wait_req = 1'b0;
  end else begin : g_cnt
    localparam logic [CW-1:0] LIM = CW'(WAIT_STATES);
    logic [CW-1:0] cnt_q, cnt_d;
    logic          cnt_en;

    always_comb begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q;
      if (!slow_acc)         cnt_d = '0;
      else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
      else                   cnt_en = 1'b0;
      wait_req = slow_acc && (cnt_q != LIM);
    end

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)    cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assert_wait_start_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
      $rose(slow_acc) |-> wait_req);
    assert_wait_stays_off_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
      (slow_acc && !wait_req) |=> !wait_req);
    assert_wait_needs_acc_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
      wait_req |-> slow_acc);
  end
endmodule

// File: rtl/memmap_cs_dec.sv
module memmap_cs_dec
  import memdec_pkg::*;
#(
  parameter int WAIT_STATES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_m,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [ROM_N-1:0]  rom_cs_n,
  output logic [RAM_N-1:0]  ram_cs_n,
  output logic              rom_oe_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic              wait_req
);
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  logic       mem_cyc, rom_hit, ram_hit, rom_acc;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign mem_cyc = !io_m;

  region_dec #(
    .ADDR_W(ADDR_W), .DEV_N(ROM_N), .IDX_LO(ROM_IDX),
    .TAG_LO(ROM_TAGL), .TAG_W(ROM_TAGW), .TAG_V(ROM_TAGV)
  ) u_rom (
    .clk(clk), .rst_n(rst_q_n), .addr(addr), .mem_cyc(mem_cyc),
    .hit(rom_hit), .sel_n(rom_cs_n)
  );

  region_dec #(
    .ADDR_W(ADDR_W), .DEV_N(RAM_N), .IDX_LO(RAM_IDX),
    .TAG_LO(RAM_TAGL), .TAG_W(RAM_TAGW), .TAG_V(RAM_TAGV)
  ) u_ram (
    .clk(clk), .rst_n(rst_q_n), .addr(addr), .mem_cyc(mem_cyc),
    .hit(ram_hit), .sel_n(ram_cs_n)
  );

  always_comb begin
    rom_oe_n = rom_hit ? rd_n : 1'b1;
    ram_oe_n = ram_hit ? rd_n : 1'b1;
    ram_we_n = ram_hit ? wr_n : 1'b1;
    rom_acc  = rom_hit && !(rd_n && wr_n);
  end

  wait_gen #(.WAIT_STATES(WAIT_STATES)) u_wait (
    .clk(clk), .rst_q_n(rst_q_n), .slow_acc(rom_acc), .wait_req(wait_req)
  );

  assert_single_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~rom_cs_n, ~ram_cs_n}) <= 1);
  assert_io_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    io_m |-> (&rom_cs_n && &ram_cs_n && rom_oe_n && ram_oe_n && ram_we_n && !wait_req));
  assert_ram_nowait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_cs_n != '1) |-> !wait_req);
  assert_rom_oe_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> (rom_cs_n != '1));
  assert_ram_en_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_oe_n || !ram_we_n) |-> (ram_cs_n != '1));
endmodule

// File: tb/sim_memmap_cs_dec.sv
module sim_memmap_cs_dec;
  localparam int WS = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] addr;
  logic        io_m, rd_n, wr_n;
  logic [7:0]  rom_cs_n;
  logic [15:0] ram_cs_n;
  logic        rom_oe_n, ram_oe_n, ram_we_n, wait_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  memmap_cs_dec #(.WAIT_STATES(WS)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .rom_oe_n(rom_oe_n),
    .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .wait_req(wait_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at the falling edge, sample 1 ns later
  task automatic drive(input logic [19:0] a, input logic io, input logic r, input logic w);
    @(negedge clk);
    addr = a; io_m = io; rd_n = r; wr_n = w;
    #1;
  endtask

  task automatic t_reset();  // R11
    rst_n = 1'b0; addr = 20'hA0000; io_m = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 selects", {8'h0, rom_cs_n, ram_cs_n}, {8'h0, 8'hFF, 16'hFFFF});
    chk("R11 enables/wait", {rom_oe_n, ram_oe_n, ram_we_n, wait_req}, 4'b1110);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_rom_sweep();  // R1, R8
    for (int i = 0; i < 8; i++) begin
      drive(20'hF8000 | (20'(i) << 12) | 20'h00ABC, 1'b0, 1'b1, 1'b1);
      chk("R1 rom select", {ram_cs_n, rom_cs_n}, {16'hFFFF, ~(8'h01 << i)});
      chk("R8 rom_oe idle", {31'h0, rom_oe_n}, 32'h1);
      drive(addr, 1'b0, 1'b0, 1'b1);
      chk("R8 rom_oe read", {29'h0, rom_oe_n, ram_oe_n, ram_we_n}, 32'h3);
      drive(addr, 1'b0, 1'b1, 1'b1);
    end
  endtask

  task automatic t_ram_sweep();  // R2, R9, R7
    for (int i = 0; i < 16; i++) begin
      drive((20'(i) << 15) | 20'h01234, 1'b0, 1'b0, 1'b1);
      chk("R2 ram select", {rom_cs_n, ram_cs_n}, {8'hFF, ~(16'h0001 << i)});
      chk("R9 ram read", {rom_oe_n, ram_oe_n, ram_we_n}, 3'b101);
      chk("R7 no wait read", {31'h0, wait_req}, 32'h0);
      drive(addr, 1'b0, 1'b1, 1'b0);
      chk("R9 ram write", {rom_oe_n, ram_oe_n, ram_we_n}, 3'b110);
      @(negedge clk); #1;
      chk("R7 no wait write", {31'h0, wait_req}, 32'h0);
      drive(addr, 1'b0, 1'b1, 1'b1);
    end
  endtask

  task automatic t_gap();  // R4
    logic [19:0] pts [4] = '{20'h80000, 20'hC1234, 20'hF0000, 20'hF7FFF};
    foreach (pts[k]) begin
      drive(pts[k], 1'b0, 1'b0, 1'b1);
      chk("R4 gap selects", {8'h0, rom_cs_n, ram_cs_n}, {8'h0, 8'hFF, 16'hFFFF});
      chk("R4 gap enables", {rom_oe_n, ram_oe_n, ram_we_n, wait_req}, 4'b1110);
    end
    drive(20'h80000, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_io();  // R3
    logic [19:0] pts [3] = '{20'hFFFF0, 20'h00010, 20'hF9000};
    foreach (pts[k]) begin
      drive(pts[k], 1'b1, 1'b0, 1'b1);
      chk("R3 io selects", {8'h0, rom_cs_n, ram_cs_n}, {8'h0, 8'hFF, 16'hFFFF});
      chk("R3 io enables", {rom_oe_n, ram_oe_n, ram_we_n, wait_req}, 4'b1110);
      @(negedge clk); #1;
      chk("R3 io no wait", {31'h0, wait_req}, 32'h0);
    end
    drive(20'h80000, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_reset_vector();  // R5
    drive(20'hFFFF0, 1'b0, 1'b1, 1'b1);
    chk("R5 reset vector", {24'h0, rom_cs_n}, 32'h7F);
  endtask

  task automatic t_rom_wait(input logic [19:0] a, input logic r, input logic w);  // R6
    drive(a, 1'b0, 1'b1, 1'b1);
    chk("R6 no strobe no wait", {31'h0, wait_req}, 32'h0);
    drive(a, 1'b0, r, w);
    for (int k = 0; k <= WS + 1; k++) begin
      chk("R6 wait window", {31'h0, wait_req}, {31'h0, (k < WS)});
      @(negedge clk); #1;
    end
    drive(a, 1'b0, 1'b1, 1'b1);
    chk("R6 wait cleared", {31'h0, wait_req}, 32'h0);
  endtask

  task automatic t_restart();  // R6: back-to-back ROM accesses
    t_rom_wait(20'hF9000, 1'b0, 1'b1);
    drive(20'hFE000, 1'b0, 1'b0, 1'b1);
    chk("R6 restart wait", {31'h0, wait_req}, 32'h1);
    drive(20'hFE000, 1'b0, 1'b1, 1'b1);
    // switch from a held ROM read straight into RAM: wait must drop
    drive(20'hF8000, 1'b0, 1'b0, 1'b1);
    drive(20'h00000, 1'b0, 1'b0, 1'b1);
    chk("R7 ram after rom", {31'h0, wait_req}, 32'h0);
    drive(20'hF8000, 1'b0, 1'b0, 1'b1);
    chk("R6 rom after ram", {31'h0, wait_req}, 32'h1);
    drive(20'h80000, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_rom_sweep();
    t_ram_sweep();
    t_gap();
    t_io();
    t_reset_vector();
    t_rom_wait(20'hFFFF0, 1'b0, 1'b1);
    t_rom_wait(20'hFA010, 1'b1, 1'b0);
    t_restart();
    done = 1'b1;
  end

  // R10 checked continuously at every falling edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && $countones({~rom_cs_n, ~ram_cs_n}) > 1) begin
      n_chk++; n_bad++;
      $display("FAIL R10: actual %h expected at most one low", {rom_cs_n, ram_cs_n});
    end
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule